// File: doc/BRIEF.md
# Byte-Writable Single-Error-Correcting Word Store

This block is a word memory with single-error correction that the rest of the chip reads and writes one byte at a time. Each entry holds a 38-bit codeword: 32 data bits plus 6 Hamming check bits. The correction granule is the whole word. A byte read therefore fetches the containing codeword, repairs it and returns one byte lane. A byte write fetches and repairs the word, replaces one lane, re-encodes all 38 bits and stores them back. A full-word write skips the fetch and encodes the supplied 32 bits directly.

A small sequencer runs each request. It has three states. `ST_IDLE` accepts a request. `ST_CHECK` decodes the fetched codeword; it returns a read result or builds the merged word for a byte write. `ST_STORE` writes the new codeword. The transitions are:

- idle-to-check, on any read or byte write;
- idle-to-store, on a full-word write;
- check-to-idle, when a read completes;
- check-to-store, for a byte write;
- store-to-idle, always.

For testing, an XOR mask supplied with each write request is applied to the codeword as it enters the array. This lets single-bit and multi-bit faults be planted at any position.

Top module: `sec_byte_store`

## Requirements
- R1: Reset leaves `busy` and `done` low and fills every word with data FFFFFFFFh and matching check bits. Any byte read after reset returns FFh with `fix_flag` and `bad_flag` low.
- R2: The codeword layout is fixed.
  - Positions are numbered 1 to 38; position p is stored in array bit p-1.
  - Check bit i sits at position 2^i.
  - Data bit j sits at the j-th position, counting upward, that is not a power of two.
  - Check bit i is the even parity of all data positions whose number has bit i set.
- R3: The word index is `req_addr >> 2`, and the lane is `req_addr[1:0]`. Lane k returns data bits [8k+7:8k]. For a read accepted at a clock edge, `busy` is high for the next cycle and `done` is high in the cycle after that.
- R4: On a fetched codeword, the syndrome is the XOR of the positions of all set bits. If it is between 1 and 38, the bit at that position is flipped before the data is used, and `fix_flag` is raised with `done`.
- R5: If the syndrome is 39 or above, `bad_flag` is raised with `done`, and the data is used as stored, without any flip.
- R6: A byte write replaces only its lane. The other three bytes keep their repaired values. `busy` is high for two cycles after acceptance, and `done` is high in the third. The flags report the decode of the old word.
- R7: A full-word write (`req_write` and `req_full` both high) stores all 32 bits of `req_wdata` without a fetch. `busy` is high for one cycle and `done` is high in the second. Both flags are low.
- R8: The `inj_mask` value sampled with a write request is XORed into the encoded codeword as it is stored.
- R9: A byte write to a word that holds a single-bit error writes back a clean codeword, so a later read of that word reports no correction.
- R10: A request presented while `busy` is high is ignored: it starts no operation and changes no memory.
- R11: `done` is a single-cycle pulse. `rd_byte` and the flags hold their values until the next operation updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | With req_write: write the whole word |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 32 | Write data; byte writes use bits [7:0] |
| inj_mask | input | 38 | Fault mask XORed into the stored codeword |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte returned by the last read |
| fix_flag | output | 1 | Last decode corrected one bit |
| bad_flag | output | 1 | Last decode found an out-of-range syndrome |

## Verification
The assertions assume the following about the inputs:
- `WORDS` is a power of two, so every byte address maps to a real word.
- The request fields are meaningful only in the cycle where `req_valid` is high while idle.

The stimulus issues each request for exactly one idle cycle. It drives extra requests only in deliberate busy-window tests. The random phase plants at most one extra error per write, through a single-bit mask. Multi-bit faults appear only in a directed case whose syndrome lies beyond position 38. This keeps the reference decode and the design on the same documented behaviour.

// File: rtl/secstore_pkg.sv
package secstore_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CW_W-1:0]   code_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_STORE
    } seq_state_t;

    // true when position p (1-based) holds a check bit
    function automatic bit is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // data bit number carried at non-check position p
    function automatic int data_index(input int p);
        int cnt;
        cnt = 0;
        for (int q = 1; q < p; q++) begin
            if (!is_pow2(q)) cnt++;
        end
        return cnt;
    endfunction

    // 1-based position that carries data bit j
    function automatic int data_pos(input int j);
        int cnt;
        int hit;
        cnt = 0;
        hit = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j) hit = p;
                cnt++;
            end
        end
        return hit;
    endfunction

    // positions covered by check bit i
    function automatic code_t cover_mask(input int i);
        code_t m;
        m = '0;
        for (int p = 1; p <= CW_W; p++) begin
            m[p-1] = ((p >> i) & 1) != 0;
        end
        return m;
    endfunction
endpackage

// File: rtl/secstore_encoder.sv
module secstore_encoder
    import secstore_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    code_t spread;

    // place data bits, leave check positions empty
    for (genvar p = 1; p <= CW_W; p++) begin : g_spread
        if (is_pow2(p)) begin : g_hole
            assign spread[p-1] = 1'b0;
        end else begin : g_bit
            assign spread[p-1] = data_i[data_index(p)];
        end
    end

    // fill each check position with the parity of its cover set
    for (genvar p = 1; p <= CW_W; p++) begin : g_out
        if (is_pow2(p)) begin : g_chk
            assign cw_o[p-1] = ^(spread & cover_mask($clog2(p)));
        end else begin : g_dat
            assign cw_o[p-1] = spread[p-1];
        end
    end
endmodule

// File: rtl/secstore_decoder.sv
module secstore_decoder
    import secstore_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fixed_o,
    output logic              bad_o
);
    localparam syn_t LAST_POS = syn_t'(CW_W);

    syn_t  syn;
    code_t flip;
    code_t repaired;

    for (genvar i = 0; i < CHK_W; i++) begin : g_syn
        assign syn[i] = ^(cw_i & cover_mask(i));
    end

    always_comb begin
        flip    = '0;
        fixed_o = 1'b0;
        bad_o   = 1'b0;
        if (syn != '0) begin
            if (syn <= LAST_POS) begin
                flip    = code_t'(1) << (syn - syn_t'(1));
                fixed_o = 1'b1;
            end else begin
                bad_o = 1'b1;
            end
        end
    end

    assign repaired = cw_i ^ flip;

    for (genvar j = 0; j < DATA_W; j++) begin : g_extract
        assign data_o[j] = repaired[data_pos(j) - 1];
    end
endmodule

// File: rtl/secstore_array.sv
module secstore_array
    import secstore_pkg::*;
#(
    parameter  int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW_W-1:0]  init_cw,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CW_W-1:0]  rd_cw,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CW_W-1:0]  wr_cw
);
    code_t cells [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                cells[w] <= init_cw;
            end
            rd_cw <= init_cw;
        end else begin
            if (wr_en) cells[wr_idx] <= wr_cw;
            if (rd_en) rd_cw <= cells[rd_idx];
        end
    end
endmodule

// File: rtl/sec_byte_store.sv
module sec_byte_store
    import secstore_pkg::*;
#(
    parameter  int WORDS  = 64,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int ADDR_W = IDX_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_full,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CW_W-1:0]   inj_mask,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_byte,
    output logic              fix_flag,
    output logic              bad_flag
);
    seq_state_t state, state_nx;

    logic              accept;
    logic              op_write;
    logic [IDX_W-1:0]  op_idx;
    logic [LANE_W-1:0] op_lane;
    logic [7:0]        op_byte;
    code_t             op_mask;
    code_t             wr_q;

    code_t             erased_cw;
    code_t             fetched_cw;
    code_t             enc_out;
    word_t             enc_in;
    word_t             dec_data;
    word_t             merged;
    logic              dec_fix;
    logic              dec_bad;

    assign accept = (state == ST_IDLE) && req_valid;
    assign busy   = (state != ST_IDLE);

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    secstore_encoder u_erase_enc (
        .data_i (word_t'('1)),
        .cw_o   (erased_cw)
    );

    secstore_array #(.WORDS(WORDS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_cw (erased_cw),
        .rd_en   (accept),
        .rd_idx  (req_addr[ADDR_W-1:LANE_W]),
        .rd_cw   (fetched_cw),
        .wr_en   (state == ST_STORE),
        .wr_idx  (op_idx),
        .wr_cw   (wr_q ^ op_mask)
    );

    secstore_decoder u_dec (
        .cw_i    (fetched_cw),
        .data_o  (dec_data),
        .fixed_o (dec_fix),
        .bad_o   (dec_bad)
    );

    always_comb begin
        merged = dec_data;
        merged[{op_lane, 3'b000} +: 8] = op_byte;
    end

    assign enc_in = (state == ST_IDLE) ? req_wdata : merged;

    secstore_encoder u_enc (
        .data_i (enc_in),
        .cw_o   (enc_out)
    );

    // ---------------------------------------------------------------
    // Sequencer
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write && req_full) state_nx = ST_STORE;
                    else                       state_nx = ST_CHECK;
                end
            end
            ST_CHECK: state_nx = op_write ? ST_STORE : ST_IDLE;
            ST_STORE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Request capture and outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_idx   <= '0;
            op_lane  <= '0;
            op_byte  <= '0;
            op_mask  <= '0;
            wr_q     <= '0;
            done     <= 1'b0;
            rd_byte  <= '0;
            fix_flag <= 1'b0;
            bad_flag <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_write <= req_write;
                        op_idx   <= req_addr[ADDR_W-1:LANE_W];
                        op_lane  <= req_addr[LANE_W-1:0];
                        op_byte  <= req_wdata[7:0];
                        op_mask  <= inj_mask;
                        if (req_write && req_full) begin
                            wr_q     <= enc_out;
                            fix_flag <= 1'b0;
                            bad_flag <= 1'b0;
                        end
                    end
                end
                ST_CHECK: begin
                    fix_flag <= dec_fix;
                    bad_flag <= dec_bad;
                    if (op_write) begin
                        wr_q <= enc_out;
                    end else begin
                        rd_byte <= dec_data[{op_lane, 3'b000} +: 8];
                        done    <= 1'b1;
                    end
                end
                ST_STORE: done <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !op_write) |=> (done && state == ST_IDLE));

    assert_byte_write_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && op_write) |=> (state == ST_STORE && !done));

    assert_store_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |=> (done && state == ST_IDLE));

    assert_full_skips_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && req_write && req_full) |=> (state == ST_STORE));

    assert_busy_ignores_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(op_idx) && $stable(op_mask)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sec_byte_store_test.sv
module sec_byte_store_test;
    localparam int NW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_full = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [37:0] inj_mask = '0;
    logic        busy, done, fix_flag, bad_flag;
    logic [7:0]  rd_byte;

    int checks = 0;
    int errors = 0;

    logic [37:0] mdl [NW];

    always #10 clk = ~clk;

    sec_byte_store #(.WORDS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_full(req_full), .req_addr(req_addr), .req_wdata(req_wdata),
        .inj_mask(inj_mask), .busy(busy), .done(done), .rd_byte(rd_byte),
        .fix_flag(fix_flag), .bad_flag(bad_flag)
    );

    // reference encoder: data ascending into non-power-of-two positions
    function automatic logic [37:0] b_enc(input logic [31:0] d);
        logic [37:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = d[k];
                k++;
            end
        end
        for (int i = 0; i < 6; i++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= 38; p++) if (p[i]) par ^= c[p-1];
            c[(1 << i) - 1] = par;
        end
        return c;
    endfunction

    // reference decoder: syndrome as XOR of set-bit positions
    function automatic void b_dec(input logic [37:0] c, output logic [31:0] d,
                                  output logic fx, output logic bd);
        int s;
        int k;
        s  = 0;
        fx = 1'b0;
        bd = 1'b0;
        for (int p = 1; p <= 38; p++) if (c[p-1]) s ^= p;
        if (s != 0) begin
            if (s <= 38) begin
                c[s-1] = ~c[s-1];
                fx = 1'b1;
            end else begin
                bd = 1'b1;
            end
        end
        d = '0;
        k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p-1];
                k++;
            end
        end
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one request; called and returns at a falling edge
    task automatic do_op(input bit wr, input bit full, input int addr,
                         input logic [31:0] wdata, input logic [37:0] mask,
                         input bit poke, input string tag);
        int idx, lane, lat, cyc;
        logic [31:0] d;
        logic fx, bd;
        logic [7:0] eb;
        idx  = addr >> 2;
        lane = addr & 3;
        fx = 1'b0; bd = 1'b0; eb = '0; d = '0; lat = 2;
        if (!wr) begin
            b_dec(mdl[idx], d, fx, bd);
            eb = d[lane*8 +: 8];
        end else if (!full) begin
            b_dec(mdl[idx], d, fx, bd);
            d[lane*8 +: 8] = wdata[7:0];
            mdl[idx] = b_enc(d) ^ mask;
            lat = 3;
        end else begin
            mdl[idx] = b_enc(wdata) ^ mask;
        end
        req_valid = 1'b1; req_write = wr; req_full = full;
        req_addr = addr[7:0]; req_wdata = wdata; inj_mask = mask;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R10: a request while busy must be ignored
            req_valid = 1'b1; req_write = 1'b1; req_full = 1'b1;
            req_addr = 8'(addr ^ 32); req_wdata = 32'hDEADBEEF; inj_mask = '0;
        end
        cyc = 1;
        chk(busy === 1'b1, tag, "busy after accept", 64'(busy), 64'd1);
        while (done !== 1'b1 && cyc < 12) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end
        chk(cyc == lat, tag, "cycles to done", 64'(cyc), 64'(lat));
        chk(fix_flag === fx, tag, "fix_flag", 64'(fix_flag), 64'(fx));
        chk(bad_flag === bd, tag, "bad_flag", 64'(bad_flag), 64'(bd));
        if (!wr) chk(rd_byte === eb, tag, "rd_byte", 64'(rd_byte), 64'(eb));
        @(negedge clk);
        chk(done === 1'b0, "R11", "done pulse width", 64'(done), 64'd0);
        if (!wr) chk(rd_byte === eb, "R11", "rd_byte held", 64'(rd_byte), 64'(eb));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int op, addr;
        logic [31:0] w;
        logic [37:0] m;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) mdl[i] = b_enc(32'hFFFFFFFF);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);

        // R1: erased contents
        do_op(0, 0, 0,   '0, '0, 0, "R1");
        do_op(0, 0, 255, '0, '0, 0, "R1");

        // R3/R7: full word then every lane
        do_op(1, 1, 4, 32'h11223344, '0, 0, "R7");
        for (int l = 0; l < 4; l++) do_op(0, 0, 4 + l, '0, '0, 0, "R3");

        // R6: byte write keeps other lanes
        do_op(1, 0, 6, 32'h000000AB, '0, 0, "R6");
        for (int l = 0; l < 4; l++) do_op(0, 0, 4 + l, '0, '0, 0, "R6");

        // R2/R4/R8: single fault at every codeword position
        for (int p = 0; p < 38; p++) begin
            do_op(1, 1, 8, 32'hA5C3_0F96, 38'(1) << p, 0, "R8");
            do_op(0, 0, 8 + (p & 3), '0, '0, 0, "R4");
            chk(fix_flag === 1'b1, "R2", "fault position corrected", 64'(fix_flag), 64'd1);
        end

        // R5: positions 33 and 6 give syndrome 39
        do_op(1, 1, 12, 32'h5A5A_5A5A, (38'(1) << 32) | (38'(1) << 5), 0, "R8");
        do_op(0, 0, 12, '0, '0, 0, "R5");
        chk(bad_flag === 1'b1, "R5", "out-of-range syndrome", 64'(bad_flag), 64'd1);

        // R9: byte write scrubs a single error
        do_op(1, 1, 16, 32'hCAFE_F00D, 38'(1) << 9, 0, "R8");
        do_op(1, 0, 17, 32'h00000077, '0, 0, "R9");
        do_op(0, 0, 16, '0, '0, 0, "R9");
        chk(fix_flag === 1'b0, "R9", "no correction after rewrite", 64'(fix_flag), 64'd0);

        // R10: requests during busy windows are ignored
        do_op(1, 0, 20, 32'h0000003C, '0, 1, "R10");
        do_op(1, 1, 24, 32'h0BAD_F00D, '0, 1, "R10");
        do_op(0, 0, 20 ^ 32, '0, '0, 1, "R10");
        do_op(0, 0, 24 ^ 32, '0, '0, 0, "R10");
        do_op(0, 0, 20 ^ 32, '0, '0, 0, "R10");

        // random mix
        for (int n = 0; n < 400; n++) begin
            op   = int'($urandom % 4);
            addr = int'($urandom % (NW * 4));
            w    = $urandom;
            m    = '0;
            if (op != 0 && ($urandom % 4) == 0) m = 38'(1) << ($urandom % 38);
            if (op == 0 || op == 1) do_op(0, 0, addr, '0, '0, 0, "R3");
            else if (op == 2)       do_op(1, 0, addr, w, m, 0, "R6");
            else                    do_op(1, 1, addr, w, m, 0, "R7");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule